// File: doc/BRIEF.md
# Float Immediate Constant Builder

This block builds floating-point constants inside a 64-bit floating-point register from 16-bit immediates. It is purely combinational. It takes an operation select, the immediate and the current register value, and it returns the value to write back.

A **load** treats the immediate as the upper half of a single-precision word whose lower half is zero. In other words, the immediate is read as a bfloat16 value, and the block widens that word to double format. An **insert** refines an earlier load. It narrows the register back to its single-precision image, replaces the low 16 bits of that image with the immediate, and widens the result again. A load followed by an insert therefore places any exact single-precision constant in the register.

The immediate can come from three instruction fields or from one assembled 16-bit port. A parameter chooses which of the two the block uses. No status or exception flag is produced by either operation.

Top module: `fimm_builder`

## Requirements
- R1: With `SPLIT_FIELDS=1` the 16-bit immediate is the concatenation {`fld_hi` (10 bits), `fld_mid` (5 bits), `fld_lo` (1 bit)}, with `fld_hi` most significant, and `imm_whole` has no effect.
- R2: When `op_sel`=0 (load), `reg_next` is the double-format value of the single-precision word {immediate, 16'h0000}. The immediates 0x0000, 0x8000, 0x3F80, 0xBF80, 0xBFC0, 0x7F80, 0xFF80 and 0x7FC0 give 0x0000000000000000, 0x8000000000000000, 0x3FF0000000000000, 0xBFF0000000000000, 0xBFF8000000000000, 0x7FF0000000000000, 0xFFF0000000000000 and 0x7FF8000000000000.
- R3: Widening a normal single (exponent field 1..254) keeps the sign, adds 896 to the exponent, and appends 29 zero bits below the 23-bit fraction.
- R4: Widening a single with a zero exponent and a non-zero fraction yields a normalised double of the same value. For example, single 0x00400000 becomes 0x3800000000000000. A signed zero stays a signed zero.
- R5: Widening a single with an all-ones exponent gives an all-ones double exponent and keeps the fraction, so infinities and NaNs survive.
- R6: When `op_sel`=1 (insert), `reg_next` is the widening of {bits 31..16 of the single image of `reg_cur`, immediate}. A load of 0x3F80 followed by an insert of 0x8000 gives 0x3FF0100000000000.
- R7: In an insert, bits 28..0 of `reg_cur` have no effect on `reg_next`.
- R8: Narrowing a double that lies in the single subnormal range is exact for any value a load produced. An insert after a load of any immediate `h` therefore equals the widening of {h, new immediate}.
- R9: Narrowing a double with an all-ones exponent gives an all-ones single exponent and the top 23 fraction bits. For example, inserting 0x0001 into +Inf (0x7FF0000000000000) gives 0x7FF0000020000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 1 | 0 = load immediate, 1 = insert low half |
| fld_hi | input | 10 | Upper 10 bits of the split immediate |
| fld_mid | input | 5 | Middle 5 bits of the split immediate |
| fld_lo | input | 1 | Lowest bit of the split immediate |
| imm_whole | input | 16 | Assembled immediate, used when SPLIT_FIELDS=0 |
| reg_cur | input | 64 | Current register value (double format) |
| reg_next | output | 64 | Value to write back (double format) |

## Verification
Every one of the 65536 immediates is loaded and compared with an independent widening. This catches a design that forgets to normalise subnormal singles, one that miscomputes the rebias, and one that clears the fraction of a NaN.

A second sweep inserts into every possible loaded value with garbage in the low register bits. It exposes a design that ORs into the double instead of narrowing first, a design that lets the discarded low bits leak through, and a design whose narrowing of subnormals shifts by one too many or too few.

Directed cases cover the field order of the split immediate, the chained 1.00390625 constant, and insertion into an infinity.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
    localparam int IMM_W    = 16;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS  = (1 << (DP_EXP_W - 1)) - 1;
    localparam int BIAS_GAP = DP_BIAS - SP_BIAS;
    localparam int MAN_PAD  = DP_MAN_W - SP_MAN_W;
    localparam int SP_EXP_MAX = (1 << SP_EXP_W) - 1;
    localparam int HI_W     = 10;
    localparam int MID_W    = 5;
    localparam int LO_W     = 1;

    typedef enum logic {
        OP_LOAD   = 1'b0,
        OP_INSERT = 1'b1
    } op_e;
endpackage

// File: rtl/fimm_imm_join.sv
module fimm_imm_join
    import fimm_pkg::*;
#(
    parameter bit SPLIT_FIELDS = 1'b1
) (
    input  logic [HI_W-1:0]  fld_hi,
    input  logic [MID_W-1:0] fld_mid,
    input  logic [LO_W-1:0]  fld_lo,
    input  logic [IMM_W-1:0] imm_whole,
    output logic [IMM_W-1:0] imm
);
    generate
        if (SPLIT_FIELDS) begin : g_split
            logic unused_whole;
            assign unused_whole = ^imm_whole;
            assign imm = {fld_hi, fld_mid, fld_lo};
        end else begin : g_whole
            logic unused_fields;
            assign unused_fields = ^{fld_hi, fld_mid, fld_lo};
            assign imm = imm_whole;
        end
    endgenerate
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow
    import fimm_pkg::*;
(
    input  logic [DP_W-1:0] dp_in,
    output logic [SP_W-1:0] sp_out
);
    logic                unused_low;
    logic                sgn;
    logic [DP_EXP_W-1:0] de;
    logic [SP_MAN_W-1:0] top_m;
    logic [SP_EXP_W-1:0] se_out;
    logic [SP_MAN_W-1:0] sm_out;
    logic [SP_MAN_W:0]   denorm;
    int                  se;

    assign unused_low = ^dp_in[MAN_PAD-1:0];

    always_comb begin
        sgn    = dp_in[DP_W-1];
        de     = dp_in[DP_W-2 -: DP_EXP_W];
        top_m  = dp_in[DP_MAN_W-1 -: SP_MAN_W];
        se     = int'(de) - BIAS_GAP;
        denorm = '0;
        se_out = '0;
        sm_out = '0;
        if (de == '1) begin
            se_out = '1;
            sm_out = top_m;
        end else if (de == '0) begin
            se_out = '0;
            sm_out = '0;
        end else if (se >= SP_EXP_MAX) begin
            se_out = '1;
            sm_out = '0;
        end else if (se >= 1) begin
            se_out = SP_EXP_W'(se);
            sm_out = top_m;
        end else if (se >= 1 - SP_MAN_W) begin
            denorm = {1'b1, top_m} >> (1 - se);
            sm_out = denorm[SP_MAN_W-1:0];
        end
        sp_out = {sgn, se_out, sm_out};

        assert_narrow_special_R9: assert (!(de == '1) || (sp_out[SP_W-2 -: SP_EXP_W] == '1))
            else $error("narrowing lost an all-ones exponent");
    end
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen
    import fimm_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output logic [DP_W-1:0] dp_out
);
    logic                sgn;
    logic [SP_EXP_W-1:0] e;
    logic [SP_MAN_W-1:0] m;
    logic [SP_MAN_W-1:0] norm_m;
    logic [DP_EXP_W-1:0] de;
    logic [DP_MAN_W-1:0] dm;
    int                  lead;

    always_comb begin
        sgn    = sp_in[SP_W-1];
        e      = sp_in[SP_W-2 -: SP_EXP_W];
        m      = sp_in[SP_MAN_W-1:0];
        lead   = 0;
        for (int i = 0; i < SP_MAN_W; i++) begin
            if (m[i]) lead = i;
        end
        norm_m = m << (SP_MAN_W - lead);
        if (e == '1) begin
            de = '1;
            dm = {m, {MAN_PAD{1'b0}}};
        end else if (e == '0 && m == '0) begin
            de = '0;
            dm = '0;
        end else if (e == '0) begin
            de = DP_EXP_W'(BIAS_GAP - SP_MAN_W + 1 + lead);
            dm = {norm_m, {MAN_PAD{1'b0}}};
        end else begin
            de = DP_EXP_W'(int'(e) + BIAS_GAP);
            dm = {m, {MAN_PAD{1'b0}}};
        end
        dp_out = {sgn, de, dm};

        assert_special_keep_R5: assert ((e == '1) == (de == '1))
            else $error("widening broke the all-ones exponent mapping");
        assert_subnorm_norm_R4: assert (!(e == '0 && m != '0) || (de != '0))
            else $error("subnormal single left unnormalised");
    end
endmodule

// File: rtl/fimm_builder.sv
module fimm_builder
    import fimm_pkg::*;
#(
    parameter bit SPLIT_FIELDS = 1'b1
) (
    input  logic        op_sel,
    input  logic [9:0]  fld_hi,
    input  logic [4:0]  fld_mid,
    input  logic        fld_lo,
    input  logic [15:0] imm_whole,
    input  logic [63:0] reg_cur,
    output logic [63:0] reg_next
);
    localparam int HALF = SP_W - IMM_W;

    op_e              op;
    logic [IMM_W-1:0] imm;
    logic [SP_W-1:0]  sp_cur;
    logic [SP_W-1:0]  sp_pick;
    logic             unused_cur_low;

    assign op             = op_e'(op_sel);
    assign unused_cur_low = ^sp_cur[HALF-1:0];

    fimm_imm_join #(.SPLIT_FIELDS(SPLIT_FIELDS)) u_join (
        .fld_hi    (fld_hi),
        .fld_mid   (fld_mid),
        .fld_lo    (fld_lo),
        .imm_whole (imm_whole),
        .imm       (imm)
    );

    fimm_narrow u_narrow (
        .dp_in  (reg_cur),
        .sp_out (sp_cur)
    );

    always_comb begin
        unique case (op)
            OP_LOAD:   sp_pick = {imm, {HALF{1'b0}}};
            OP_INSERT: sp_pick = {sp_cur[SP_W-1 -: IMM_W], imm};
            default:   sp_pick = '0;
        endcase
    end

    fimm_widen u_widen (
        .sp_in  (sp_pick),
        .dp_out (reg_next)
    );

    always_comb begin
        assert_load_low_R2: assert (!(op == OP_LOAD) || (reg_next[MAN_PAD+HALF-1:0] == '0))
            else $error("load produced bits below the immediate");
        assert_insert_sign_R6: assert (!(op == OP_INSERT) || (reg_next[DP_W-1] == reg_cur[DP_W-1]))
            else $error("insert changed the sign");
    end
endmodule

// File: tb/fimm_builder_test.sv
`timescale 1ns/1ps
module fimm_builder_test;
    logic        clk = 1'b0;
    logic        op_sel;
    logic [9:0]  fld_hi;
    logic [4:0]  fld_mid;
    logic        fld_lo;
    logic [15:0] imm_whole;
    logic [63:0] reg_cur;
    logic [63:0] reg_next;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    fimm_builder uut (
        .op_sel    (op_sel),
        .fld_hi    (fld_hi),
        .fld_mid   (fld_mid),
        .fld_lo    (fld_lo),
        .imm_whole (imm_whole),
        .reg_cur   (reg_cur),
        .reg_next  (reg_next)
    );

    function automatic logic [63:0] ref_widen(input logic [31:0] s);
        logic [7:0]  e;
        logic [23:0] mm;
        int          ex;
        e  = s[30:23];
        mm = {1'b0, s[22:0]};
        if (e == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'h0};
        if (e == 8'h00 && s[22:0] == 23'h0) return {s[31], 63'h0};
        if (e == 8'h00) begin
            ex = 1023 - 126;
            while (!mm[23]) begin
                mm = mm << 1;
                ex = ex - 1;
            end
            return {s[31], 11'(ex), mm[22:0], 29'h0};
        end
        return {s[31], 11'(int'(e) + 896), s[22:0], 29'h0};
    endfunction

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic op, input logic [15:0] imm, input logic [15:0] whole,
                         input logic [63:0] rv);
        @(negedge clk);
        op_sel    = op;
        fld_hi    = imm[15:6];
        fld_mid   = imm[5:1];
        fld_lo    = imm[0];
        imm_whole = whole;
        reg_cur   = rv;
        #2;
    endtask

    task automatic t_fields_r1();
        apply(1'b0, 16'h3F80, 16'h0000, 64'h0);
        check64("R1 split fields 0x3F80", reg_next, 64'h3FF0000000000000);
        apply(1'b0, 16'hC001, 16'h3F80, 64'h0);
        check64("R1 imm_whole ignored", reg_next, ref_widen(32'hC0010000));
    endtask

    task automatic t_constants_r2();
        logic [15:0] ins [8] = '{16'h0000, 16'h8000, 16'h3F80, 16'hBF80,
                                 16'hBFC0, 16'h7F80, 16'hFF80, 16'h7FC0};
        logic [63:0] outs [8] = '{64'h0000000000000000, 64'h8000000000000000,
                                  64'h3FF0000000000000, 64'hBFF0000000000000,
                                  64'hBFF8000000000000, 64'h7FF0000000000000,
                                  64'hFFF0000000000000, 64'h7FF8000000000000};
        for (int k = 0; k < 8; k++) begin
            apply(1'b0, ins[k], 16'h0, 64'hFFFF_FFFF_FFFF_FFFF);
            check64("R2 named constant", reg_next, outs[k]);
        end
    endtask

    task automatic t_subnormal_r4();
        apply(1'b0, 16'h0040, 16'h0, 64'h0);
        check64("R4 subnormal 0x0040 normalised", reg_next, 64'h3800000000000000);
        apply(1'b0, 16'h0001, 16'h0, 64'h0);
        check64("R4 smallest loadable subnormal", reg_next, ref_widen(32'h00010000));
    endtask

    task automatic t_load_sweep_r3();
        for (int v = 0; v < 65536; v++) begin
            apply(1'b0, 16'(v), 16'(~v), 64'h0);
            check64("R3 R4 R5 load sweep", reg_next, ref_widen({16'(v), 16'h0}));
        end
    endtask

    task automatic t_chain_r6();
        apply(1'b0, 16'h3F80, 16'h0, 64'h0);
        apply(1'b1, 16'h8000, 16'h0, reg_next);
        check64("R6 load 0x3F80 then insert 0x8000", reg_next, 64'h3FF0100000000000);
    endtask

    task automatic t_ignore_r7();
        apply(1'b1, 16'h8000, 16'h0, 64'h3FF0100000000000 | 64'h1FFFFFFF);
        check64("R7 low register bits ignored", reg_next, 64'h3FF0100000000000);
    endtask

    task automatic t_insert_sweep_r8();
        for (int h = 0; h < 65536; h++) begin
            logic [15:0] lo;
            logic [63:0] junk;
            lo   = 16'(h) ^ 16'hA5C3;
            junk = {35'h0, 29'({16'(h), 13'(h * 7)})};
            apply(1'b1, lo, 16'h0, ref_widen({16'(h), 16'h0}) | junk);
            check64("R8 R7 insert after load sweep", reg_next, ref_widen({16'(h), lo}));
        end
    endtask

    task automatic t_special_r9();
        apply(1'b1, 16'h0001, 16'h0, 64'h7FF0000000000000);
        check64("R9 insert into +Inf", reg_next, 64'h7FF0000020000000);
        apply(1'b1, 16'h0000, 16'h0, 64'hFFF8000000000000);
        check64("R9 insert into -qNaN", reg_next, 64'hFFF8000000000000);
    endtask

    initial begin
        op_sel = 1'b0; fld_hi = '0; fld_mid = '0; fld_lo = 1'b0;
        imm_whole = '0; reg_cur = '0;
        #3;
        check64("R2 idle inputs give +0.0", reg_next, 64'h0);
        t_fields_r1();
        t_constants_r2();
        t_subnormal_r4();
        t_chain_r6();
        t_ignore_r7();
        t_special_r9();
        t_load_sweep_r3();
        t_insert_sweep_r8();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1900000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule